// File: doc/BRIEF.md
# Hibernate Power Mode Controller

This block decides when a small processor core enters and leaves its deepest low-power state. The pipeline raises a one-cycle request when it executes the dedicated hibernate instruction. The controller then drops the clock enables of every core unit and of the two external clock outputs: the bus clock output and the master clock output. Register and cache contents stay intact, because the controller never issues a reset or a clear.

The controller runs entirely on the always-on 32 kHz clock, which keeps running during hibernate. There are three wake sources: a power-button input, a wake-up timer interrupt and a modem carrier-detect input. The power-button and carrier-detect inputs are asynchronous, so each passes through a flop synchronizer. The timer interrupt already comes from the 32 kHz domain and is used as it arrives. Any wake event returns the core straight to full-speed mode. The core enables come back first, and the external clock outputs follow a fixed number of cycles later. A mode output and a one-cycle change pulse let the rest of the chip follow each transition.

Top module: `hib_pwr_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the mode output is 0 (full speed), the change pulse is 0, and every core enable and both external clock enables are 1.
- R2: A request on `hib_req_i` in full-speed mode with no wake event pending sets the mode output to 1 (hibernate) after the next rising clock edge. In that same cycle, every core enable and both external clock enables go to 0.
- R3: While the mode is 1, all enables stay 0 and further hibernate requests have no effect, until a wake event occurs.
- R4: The power-button input (source bit 0) and the carrier-detect input (source bit 2) each pass through a 2-flop synchronizer. An assertion seen at rising edge k brings the mode back to 0 and the core enables back to 1 after rising edge k+2.
- R5: The timer interrupt (source bit 1) is not synchronized. If it is asserted at rising edge k, the mode returns to 0 and the core enables return after edge k.
- R6: On wake, the bus and master clock enables return exactly EXT_DELAY cycles (default 1) after the core enables. Until then, the core enables are 1 and the external enables are 0.
- R7: If a wake event and a hibernate request are present in the same cycle, the wake event wins. The mode stays 0, all enables stay 1, and no change pulse is issued.
- R8: The change pulse is high for exactly one cycle on each change of the mode output, in the first cycle that shows the new mode. It is 0 at all other times.
- R9: Wake inputs asserted while in full-speed mode with no hibernate request have no effect: the mode stays 0, all enables stay 1, and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon_i | input | 1 | Always-on 32 kHz clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| hib_req_i | input | 1 | Hibernate instruction executed (one-cycle request, synchronous) |
| pwr_btn_i | input | 1 | Power-button wake input, asynchronous |
| wake_tmr_irq_i | input | 1 | Wake-up timer interrupt, synchronous to clk_aon_i |
| carrier_det_i | input | 1 | Modem carrier-detect wake input, asynchronous |
| core_clk_en_o | output | N_UNITS | Clock enables of the core units |
| bus_clk_en_o | output | 1 | Enable of the external bus clock output |
| mst_clk_en_o | output | 1 | Enable of the external master clock output |
| pwr_mode_o | output | 1 | Power mode: 0 full speed, 1 hibernate |
| mode_chg_o | output | 1 | One-cycle pulse on each mode change |

## Verification
The assertions assume three things about the inputs. `hib_req_i` and the timer interrupt change only away from the active edge of the always-on clock. A wake input, once raised, stays high at least as long as the synchronizer needs to pass it on. The hibernate request is never asserted during the short re-arm window after a wake. The bench drives every input on the falling edge and holds each asynchronous wake input for at least three cycles. It raises hibernate requests only once the external enables are back on, except in the scenario that checks requests are ignored inside hibernate.

// File: rtl/hib_pkg.sv
package hib_pkg;

   // Controller states. HIB is the only state that reports hibernate mode.
   typedef enum logic [1:0] {
      PM_FULL  = 2'd0,
      PM_HIB   = 2'd1,
      PM_REARM = 2'd2
   } pm_state_e;

   // Wake source indices on the internal wake vector
   localparam int unsigned WK_PWR = 0;
   localparam int unsigned WK_TMR = 1;
   localparam int unsigned WK_CD  = 2;
   localparam int unsigned WK_N   = 3;

endpackage

// File: rtl/hib_wake_sync.sv
module hib_wake_sync #(
   parameter int unsigned N_SRC       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [N_SRC-1:0] SYNC_MASK = '1
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [N_SRC-1:0] raw_i,
   output logic [N_SRC-1:0] wake_o
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("hib_wake_sync: SYNC_STAGES must be at least 2");
   end
   if (N_SRC < 1) begin : g_bad_src
      $error("hib_wake_sync: N_SRC must be at least 1");
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      if (SYNC_MASK[s]) begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) chain_q <= '0;
            else          chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i[s]};
         end
         assign wake_o[s] = chain_q[SYNC_STAGES-1];
      end else begin : g_direct
         assign wake_o[s] = raw_i[s];
      end
   end

endmodule

// File: rtl/hib_mode_fsm.sv
module hib_mode_fsm
   import hib_pkg::*;
#(
   parameter int unsigned EXT_DELAY = 1
) (
   input  logic      clk_i,
   input  logic      rst_n_i,
   input  logic      hib_req_i,
   input  logic      wake_any_i,
   output pm_state_e state_o,
   output logic      mode_chg_o
);

   localparam int unsigned CW = (EXT_DELAY < 2) ? 1 : $clog2(EXT_DELAY);

   if (EXT_DELAY < 1) begin : g_bad_delay
      $error("hib_mode_fsm: EXT_DELAY must be at least 1");
   end

   pm_state_e state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic chg_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         PM_FULL: begin
            if (hib_req_i && !wake_any_i) state_d = PM_HIB;
         end
         PM_HIB: begin
            if (wake_any_i) begin
               state_d = PM_REARM;
               cnt_d   = CW'(EXT_DELAY - 1);
            end
         end
         PM_REARM: begin
            if (cnt_q == '0) state_d = PM_FULL;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: state_d = PM_FULL;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         state_q <= PM_FULL;
         cnt_q   <= '0;
         chg_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         chg_q   <= (state_d == PM_HIB) != (state_q == PM_HIB);
      end
   end

   assign state_o    = state_q;
   assign mode_chg_o = chg_q;

   // R2: a clean request in full speed enters hibernate
   assert_enter_on_req_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == PM_FULL && hib_req_i && !wake_any_i) |=> (state_q == PM_HIB));

   // R3: hibernate holds until a wake event
   assert_hold_hib_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == PM_HIB && !wake_any_i) |=> (state_q == PM_HIB));

   // R7: a wake event beats a simultaneous request
   assert_wake_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == PM_FULL && wake_any_i) |=> (state_q == PM_FULL));

   // R4 and R5: a wake in hibernate leaves it at the next edge
   assert_wake_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (state_q == PM_HIB && wake_any_i) |=> (state_q == PM_REARM));

endmodule

// File: rtl/hib_clk_en.sv
module hib_clk_en
   import hib_pkg::*;
#(
   parameter int unsigned N_UNITS = 4
) (
   input  pm_state_e          state_i,
   output logic [N_UNITS-1:0] core_en_o,
   output logic               bus_en_o,
   output logic               mst_en_o
);

   if (N_UNITS < 1) begin : g_bad_units
      $error("hib_clk_en: N_UNITS must be at least 1");
   end

   logic core_on, ext_on;
   assign core_on = (state_i != PM_HIB);
   assign ext_on  = (state_i == PM_FULL);

   for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
      assign core_en_o[u] = core_on;
   end

   assign bus_en_o = ext_on;
   assign mst_en_o = ext_on;

endmodule

// File: rtl/hib_pwr_ctrl.sv
module hib_pwr_ctrl
   import hib_pkg::*;
#(
   parameter int unsigned N_UNITS     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EXT_DELAY   = 1,
   parameter logic [2:0]  SYNC_MASK   = 3'b101
) (
   input  logic               clk_aon_i,
   input  logic               rst_n_i,
   input  logic               hib_req_i,
   input  logic               pwr_btn_i,
   input  logic               wake_tmr_irq_i,
   input  logic               carrier_det_i,
   output logic [N_UNITS-1:0] core_clk_en_o,
   output logic               bus_clk_en_o,
   output logic               mst_clk_en_o,
   output logic               pwr_mode_o,
   output logic               mode_chg_o
);

   logic [WK_N-1:0] wake_raw, wake_vec;
   logic            wake_any;
   pm_state_e       state;

   assign wake_raw[WK_PWR] = pwr_btn_i;
   assign wake_raw[WK_TMR] = wake_tmr_irq_i;
   assign wake_raw[WK_CD]  = carrier_det_i;

   hib_wake_sync #(
      .N_SRC      (WK_N),
      .SYNC_STAGES(SYNC_STAGES),
      .SYNC_MASK  (SYNC_MASK)
   ) i_sync (
      .clk_i  (clk_aon_i),
      .rst_n_i(rst_n_i),
      .raw_i  (wake_raw),
      .wake_o (wake_vec)
   );

   assign wake_any = |wake_vec;

   hib_mode_fsm #(
      .EXT_DELAY(EXT_DELAY)
   ) i_fsm (
      .clk_i     (clk_aon_i),
      .rst_n_i   (rst_n_i),
      .hib_req_i (hib_req_i),
      .wake_any_i(wake_any),
      .state_o   (state),
      .mode_chg_o(mode_chg_o)
   );

   hib_clk_en #(
      .N_UNITS(N_UNITS)
   ) i_en (
      .state_i  (state),
      .core_en_o(core_clk_en_o),
      .bus_en_o (bus_clk_en_o),
      .mst_en_o (mst_clk_en_o)
   );

   assign pwr_mode_o = (state == PM_HIB);

   // R2 and R3: hibernate mode means every enable is off
   assert_hib_all_off_R3: assert property (@(posedge clk_aon_i) disable iff (!rst_n_i)
      pwr_mode_o |-> (core_clk_en_o == '0 && !bus_clk_en_o && !mst_clk_en_o));

   // R6: the external enables only come back once the core has run a cycle
   assert_ext_after_core_R6: assert property (@(posedge clk_aon_i) disable iff (!rst_n_i)
      $rose(bus_clk_en_o) |-> (&core_clk_en_o && $past(&core_clk_en_o) && mst_clk_en_o));

   // R8: a pulse marks a change of mode
   assert_pulse_on_change_R8: assert property (@(posedge clk_aon_i) disable iff (!rst_n_i)
      mode_chg_o |-> (pwr_mode_o != $past(pwr_mode_o)));

   // R8: every change of mode carries a pulse
   assert_change_has_pulse_R8: assert property (@(posedge clk_aon_i) disable iff (!rst_n_i)
      (pwr_mode_o != $past(pwr_mode_o)) |-> mode_chg_o);

endmodule

// File: tb/test_hib_pwr_ctrl.sv
module test_hib_pwr_ctrl;

   localparam int N_UNITS = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic hib_req, pwr_btn, tmr_irq, carrier;
   logic [N_UNITS-1:0] core_en;
   logic bus_en, mst_en, mode, chg;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   hib_pwr_ctrl #(.N_UNITS(N_UNITS)) i_hib_pwr_ctrl (
      .clk_aon_i     (clk),
      .rst_n_i       (rst_n),
      .hib_req_i     (hib_req),
      .pwr_btn_i     (pwr_btn),
      .wake_tmr_irq_i(tmr_irq),
      .carrier_det_i (carrier),
      .core_clk_en_o (core_en),
      .bus_clk_en_o  (bus_en),
      .mst_clk_en_o  (mst_en),
      .pwr_mode_o    (mode),
      .mode_chg_o    (chg)
   );

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Checks mode, pulse, core enables (all on/off) and external enables
   task automatic chk_all(string req, int m, int p, int c, int e);
      chk(req, "mode", int'(mode), m);
      chk(req, "pulse", int'(chg), p);
      chk(req, "core_en", int'(core_en), c ? (1 << N_UNITS) - 1 : 0);
      chk(req, "bus_en", int'(bus_en), e);
      chk(req, "mst_en", int'(mst_en), e);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; hib_req = 0; pwr_btn = 0; tmr_irq = 0; carrier = 0;
      step(3);
      chk_all("R1", 0, 0, 1, 1);
      rst_n = 1'b1;
      step(2);
      chk_all("R1", 0, 0, 1, 1);
   endtask

   task automatic t_enter();
      hib_req = 1;
      step();
      hib_req = 0;
      chk_all("R2", 1, 1, 0, 0);
      step();
      chk_all("R8", 1, 0, 0, 0);
   endtask

   task automatic t_hold();
      for (int i = 0; i < 4; i++) begin
         hib_req = 1;
         step();
         chk_all("R3", 1, 0, 0, 0);
      end
      hib_req = 0;
      step(3);
      chk_all("R3", 1, 0, 0, 0);
   endtask

   // Asynchronous wake source: sel 0 power button, 1 carrier detect
   task automatic t_wake_async(int sel);
      if (sel == 0) pwr_btn = 1; else carrier = 1;
      step();
      chk_all("R4", 1, 0, 0, 0);
      step();
      chk_all("R4", 1, 0, 0, 0);
      step();
      chk_all("R4", 0, 1, 1, 0);
      pwr_btn = 0; carrier = 0;
      step();
      chk_all("R6", 0, 0, 1, 1);
      step(3);
      chk_all("R6", 0, 0, 1, 1);
   endtask

   task automatic t_wake_tmr();
      tmr_irq = 1;
      step();
      tmr_irq = 0;
      chk_all("R5", 0, 1, 1, 0);
      step();
      chk_all("R6", 0, 0, 1, 1);
   endtask

   task automatic t_priority_tmr();
      tmr_irq = 1; hib_req = 1;
      step();
      tmr_irq = 0; hib_req = 0;
      chk_all("R7", 0, 0, 1, 1);
      step();
      chk_all("R7", 0, 0, 1, 1);
   endtask

   task automatic t_priority_sync();
      carrier = 1;
      step(2);
      hib_req = 1;
      step();
      hib_req = 0;
      chk_all("R7", 0, 0, 1, 1);
      carrier = 0;
      step(3);
      chk_all("R7", 0, 0, 1, 1);
   endtask

   task automatic t_ignore_in_full();
      pwr_btn = 1; carrier = 1; tmr_irq = 1;
      for (int i = 0; i < 4; i++) begin
         step();
         chk_all("R9", 0, 0, 1, 1);
      end
      pwr_btn = 0; carrier = 0; tmr_irq = 0;
      step(3);
      chk_all("R9", 0, 0, 1, 1);
   endtask

   initial begin
      rst_n = 0; hib_req = 0; pwr_btn = 0; tmr_irq = 0; carrier = 0;
      step();
      t_reset();
      t_ignore_in_full();
      t_enter();
      t_hold();
      t_wake_async(0);
      t_enter();
      t_wake_async(1);
      t_enter();
      t_wake_tmr();
      t_priority_tmr();
      t_priority_sync();
      t_enter();
      t_wake_tmr();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 100000; i++) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule